// File: doc/BRIEF.md
# Secondary Core Release Table

This block keeps a small memory-mapped table with one fixed-size record per processor slot. It is used to bring up secondary cores, which are held halted after reset. The boot core fills in a record over a simple bus slave port. Each record holds a 64-bit start address, a 64-bit argument, a core identifier and two reserved fields. Fields that span several bytes are kept and returned most-significant byte first.

Bit 0 of the start address acts as a hold flag. When an accepted write leaves that flag clear, the block raises a single-cycle wake strobe for that core. Alongside the strobe it presents a payload:

- the start address split into a 64 MiB-aligned window base and an offset inside that window,
- the argument value,
- the window size.

At the same clock edge the block copies the core's own hardware identifier into the record.

Writes to the boot core's slot are discarded, and so are writes to slots that have no core behind them. Reads of any slot have no side effects.

Top module: `srt_release_table`

## Requirements
- R1: After reset, every slot i holds start address 1, argument i and core identifier i, and every other byte is zero. No wake strobe is raised.
- R2: Each slot is 32 bytes, and the slot index is the bus offset divided by 32. The start address occupies bytes 0..7, the argument bytes 8..15 and the core identifier bytes 20..23. Each field is stored most-significant byte first, and a read returns the addressed bytes in that order.
- R3: bus_size encodes 0 = byte, 1 = halfword, 2 = word. The data sits in the low bits of bus_wdata, and the first addressed byte takes the most significant of them. A halfword access ignores offset bit 0, and a word access ignores offset bits 1..0.
- R4: Writes to slot 0, and writes to any slot at or above CORES, leave the table unchanged and raise no strobe.
- R5: After an accepted write that leaves bit 0 of the slot's start address at 0, wake[slot] is high for exactly the one cycle following the write edge. At most one wake bit is ever high. While bit 0 stays 1, no strobe is raised.
- R6: With a strobe, wake_ofs is the start address masked to its low WIN_BITS bits, and wake_base is the start address with those bits cleared. wake_size is 2^WIN_BITS.
- R7: With a strobe, wake_arg is the slot's argument value as it stands after the triggering write.
- R8: At the releasing write edge, the released slot's core identifier field is overwritten with that core's word from core_hwid.
- R9: A released slot raises no further strobe on writes that keep bit 0 clear. After a write sets bit 0 back to 1, a later write that clears it releases the core again.
- R10: A read with bus_size 3 returns zero and pulses bus_rd_err one cycle later. A write with bus_size 3 is ignored.
- R11: Reads return the registered data one cycle after the request and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset into the table |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, registered, right-aligned |
| bus_rd_err | output | 1 | Illegal read size strobe |
| core_hwid | input | 32*CORES | Hardware identifier of each core |
| wake | output | CORES | One-cycle release strobe per core |
| wake_ofs | output | 64 | Start offset inside the window |
| wake_base | output | 64 | Window base address |
| wake_arg | output | 64 | Argument handed to the core |
| wake_size | output | 64 | Window size |

## Verification
The hardest state to reach is a released slot that gets more writes while its hold flag stays clear. Reaching it takes a piecewise write sequence: the high start word, then a low word with the hold flag set, then a byte write that clears only the flag, then further byte writes into the same address. The bench re-enters the hold state on purpose to show that the strobe re-arms. It also sweeps every word of every slot in a small configuration, and derives the expected record contents and the split payload from the slot number and the written values.

// File: rtl/srt_pkg.sv
package srt_pkg;
   localparam int ENTRY_BYTES = 32;
   localparam int OFS_START   = 0;
   localparam int OFS_ARG     = 8;
   localparam int OFS_ID      = 20;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   function automatic int lane_n(input acc_size_e sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         SZ_WORD: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int lane_lo(input logic [4:0] ofs, input acc_size_e sz);
      case (sz)
         SZ_HALF: return int'({ofs[4:1], 1'b0});
         SZ_WORD: return int'({ofs[4:2], 2'b00});
         default: return int'(ofs);
      endcase
   endfunction

   function automatic logic [63:0] be64(input logic [255:0] ent, input int ofs);
      logic [63:0] r;
      r = '0;
      for (int j = 0; j < 8; j++) r = {r[55:0], ent[8*(ofs+j) +: 8]};
      return r;
   endfunction

   function automatic logic [255:0] rst_image(input int idx);
      logic [255:0] img;
      logic [63:0]  v;
      img = '0;
      v   = 64'(idx);
      img[8*7 +: 8] = 8'd1;
      for (int j = 0; j < 8; j++) img[8*(OFS_ARG+7-j) +: 8] = v[8*j +: 8];
      for (int j = 0; j < 4; j++) img[8*(OFS_ID+3-j) +: 8] = v[8*j +: 8];
      return img;
   endfunction
endpackage

// File: rtl/srt_lanes.sv
module srt_lanes
   import srt_pkg::*;
(
   input  logic        wr_en,
   input  logic [4:0]  ofs,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   output logic [31:0] byte_we,
   output logic [255:0] byte_wd
);
   acc_size_e sz;
   assign sz = acc_size_e'(size);

   always_comb begin
      int n;
      int lo;
      byte_we = '0;
      byte_wd = '0;
      n  = lane_n(sz);
      lo = lane_lo(ofs, sz);
      for (int j = 0; j < 4; j++) begin
         if (wr_en && j < n) begin
            byte_we[lo+j]          = 1'b1;
            byte_wd[8*(lo+j) +: 8] = wdata[8*(n-1-j) +: 8];
         end
      end
   end
endmodule

// File: rtl/srt_entry.sv
module srt_entry
   import srt_pkg::*;
#(
   parameter int IDX = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [31:0]  byte_we,
   input  logic [255:0] byte_wd,
   input  logic         stamp,
   input  logic [31:0]  stamp_id,
   output logic [255:0] ent,
   output logic [255:0] nxt
);
   localparam logic [255:0] IMG = rst_image(IDX);

   always_comb begin
      for (int k = 0; k < ENTRY_BYTES; k++)
         nxt[8*k +: 8] = byte_we[k] ? byte_wd[8*k +: 8] : ent[8*k +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent <= IMG;
      end else begin
         ent <= nxt;
         if (stamp)
            for (int j = 0; j < 4; j++)
               ent[8*(OFS_ID+j) +: 8] <= stamp_id[8*(3-j) +: 8];
      end
   end
endmodule

// File: rtl/srt_release.sv
module srt_release #(
   parameter int CORES    = 4,
   parameter int WIN_BITS = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CORES-1:0] sel,
   input  logic [63:0]      sel_start,
   input  logic [63:0]      sel_arg,
   output logic [CORES-1:0] fire,
   output logic [CORES-1:0] wake,
   output logic [63:0]      wake_ofs,
   output logic [63:0]      wake_base,
   output logic [63:0]      wake_arg
);
   localparam logic [63:0] MASK = (64'd1 << WIN_BITS) - 64'd1;

   logic [CORES-1:0] gone_q;

   always_comb begin
      for (int i = 0; i < CORES; i++)
         fire[i] = sel[i] && !sel_start[0] && !gone_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gone_q    <= '0;
         wake      <= '0;
         wake_ofs  <= '0;
         wake_base <= '0;
         wake_arg  <= '0;
      end else begin
         wake <= fire;
         for (int i = 0; i < CORES; i++)
            if (sel[i]) gone_q[i] <= !sel_start[0];
         if (|fire) begin
            wake_ofs  <= sel_start & MASK;
            wake_base <= sel_start & ~MASK;
            wake_arg  <= sel_arg;
         end
      end
   end
endmodule

// File: rtl/srt_release_table.sv
module srt_release_table
   import srt_pkg::*;
#(
   parameter int SLOTS    = 32,
   parameter int CORES    = 4,
   parameter int WIN_BITS = 26,
   localparam int SW      = $clog2(SLOTS),
   localparam int AW      = SW + 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [1:0]          bus_size,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rd_err,
   input  logic [32*CORES-1:0] core_hwid,
   output logic [CORES-1:0]    wake,
   output logic [63:0]         wake_ofs,
   output logic [63:0]         wake_base,
   output logic [63:0]         wake_arg,
   output logic [63:0]         wake_size
);
   if (CORES < 2 || CORES > SLOTS) begin : g_bad_cores
      $error("CORES must lie in 2..SLOTS");
   end
   if ((1 << SW) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two");
   end
   if (WIN_BITS < 1 || WIN_BITS > 63) begin : g_bad_win
      $error("WIN_BITS must lie in 1..63");
   end

   acc_size_e        sz;
   logic [SW-1:0]    slot;
   logic             wr_ok;
   logic [31:0]      byte_we;
   logic [255:0]     byte_wd;
   logic [255:0]     ent_q [SLOTS];
   logic [255:0]     nxt   [CORES];
   logic [CORES-1:0] hit;
   logic [CORES-1:0] fire;
   logic [63:0]      sel_start;
   logic [63:0]      sel_arg;

   assign sz        = acc_size_e'(bus_size);
   assign slot      = bus_addr[AW-1:5];
   assign wr_ok     = bus_wr && (sz != SZ_BAD);
   assign wake_size = 64'd1 << WIN_BITS;

   srt_lanes u_lanes (
      .wr_en   (wr_ok),
      .ofs     (bus_addr[4:0]),
      .size    (bus_size),
      .wdata   (bus_wdata),
      .byte_we (byte_we),
      .byte_wd (byte_wd)
   );

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_boot
         assign ent_q[g] = rst_image(g);
         assign nxt[g]   = '0;
         assign hit[g]   = 1'b0;
      end else if (g < CORES) begin : g_live
         assign hit[g] = wr_ok && (slot == SW'(g));
         srt_entry #(.IDX(g)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_we  (byte_we & {32{hit[g]}}),
            .byte_wd  (byte_wd),
            .stamp    (fire[g]),
            .stamp_id (core_hwid[32*g +: 32]),
            .ent      (ent_q[g]),
            .nxt      (nxt[g])
         );
      end else begin : g_empty
         assign ent_q[g] = rst_image(g);
      end
   end

   always_comb begin
      sel_start = '0;
      sel_arg   = '0;
      for (int i = 1; i < CORES; i++) begin
         if (hit[i]) begin
            sel_start = be64(nxt[i], OFS_START);
            sel_arg   = be64(nxt[i], OFS_ARG);
         end
      end
   end

   srt_release #(.CORES(CORES), .WIN_BITS(WIN_BITS)) u_rel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (hit),
      .sel_start (sel_start),
      .sel_arg   (sel_arg),
      .fire      (fire),
      .wake      (wake),
      .wake_ofs  (wake_ofs),
      .wake_base (wake_base),
      .wake_arg  (wake_arg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rd_err <= 1'b0;
      end else begin
         bus_rd_err <= 1'b0;
         if (bus_rd) begin
            if (sz == SZ_BAD) begin
               bus_rdata  <= '0;
               bus_rd_err <= 1'b1;
            end else begin
               logic [31:0]  r;
               logic [255:0] e;
               int n;
               int lo;
               r  = '0;
               e  = ent_q[slot];
               n  = lane_n(sz);
               lo = lane_lo(bus_addr[4:0], sz);
               for (int j = 0; j < 4; j++)
                  if (j < n) r = {r[23:0], e[8*(lo+j) +: 8]};
               bus_rdata <= r;
            end
         end
      end
   end
endmodule

// File: rtl/srt_release_table_chk.sv
module srt_release_table_chk #(
   parameter int CORES    = 4,
   parameter int WIN_BITS = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [1:0]       bus_size,
   input logic             bus_rd_err,
   input logic [CORES-1:0] wake,
   input logic [63:0]      wake_ofs,
   input logic [63:0]      wake_base
);
   p_wake_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake));

   p_boot_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wake[0]);

   p_wake_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake) |-> $past(bus_wr));

   p_ofs_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake) |-> ((wake_ofs >> WIN_BITS) == 64'd0 && !wake_ofs[0]));

   p_base_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake) |-> ((wake_base & ((64'd1 << WIN_BITS) - 64'd1)) == 64'd0));

   p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake) |=> ((wake & $past(wake)) == '0));

   p_err_only_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_err |-> $past(bus_rd && bus_size == 2'd3));
endmodule

bind srt_release_table srt_release_table_chk #(.CORES(CORES), .WIN_BITS(WIN_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_size   (bus_size),
   .bus_rd_err (bus_rd_err),
   .wake       (wake),
   .wake_ofs   (wake_ofs),
   .wake_base  (wake_base)
);

// File: tb/srt_release_table_test.sv
`timescale 1ns/1ps
module srt_release_table_test;
   localparam int SLOTS = 8;
   localparam int CORES = 4;
   localparam int WINB  = 26;
   localparam int AW    = 8;
   localparam logic [63:0] MSK = (64'd1 << WINB) - 64'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_size = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_rd_err;
   logic [32*CORES-1:0] core_hwid;
   logic [CORES-1:0] wake;
   logic [63:0] wake_ofs, wake_base, wake_arg, wake_size;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   for (genvar c = 0; c < CORES; c++) begin : g_id
      assign core_hwid[32*c +: 32] = 32'hC0DE_0000 + 32'(c * 17);
   end

   srt_release_table #(.SLOTS(SLOTS), .CORES(CORES), .WIN_BITS(WINB)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rd_err(bus_rd_err), .core_hwid(core_hwid), .wake(wake), .wake_ofs(wake_ofs),
      .wake_base(wake_base), .wake_arg(wake_arg), .wake_size(wake_size));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // write; returns wake vector seen in the cycle after the write edge
   task automatic wr(input int slot, input int ofs, input logic [1:0] sz, input logic [31:0] d,
                     output logic [CORES-1:0] w);
      @(negedge clk);
      bus_addr = AW'(slot * 32 + ofs); bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      w = wake;
   endtask

   task automatic rd(input int slot, input int ofs, input logic [1:0] sz,
                     output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = AW'(slot * 32 + ofs); bus_size = sz; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; e = bus_rd_err;
   endtask

   function automatic logic [31:0] reset_word(input int slot, input int ofs);
      case (ofs)
         4:  return 32'd1;
         12: return 32'(slot);
         20: return 32'(slot);
         default: return 32'd0;
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic e;
      logic [CORES-1:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: no strobe after reset
      chk(wake == '0, "R1 wake idle", 64'(wake), 64'd0);

      // R1 R2: sweep every word of every slot
      for (int s = 0; s < SLOTS; s++)
         for (int o = 0; o < 32; o += 4) begin
            rd(s, o, 2'd2, d, e);
            chk(d == reset_word(s, o), "R1 R2 reset word", 64'(d), 64'(reset_word(s, o)));
         end

      // R2 R3: byte and halfword reads
      for (int b = 0; b < 8; b++) begin
         rd(3, b, 2'd0, d, e);
         chk(d == ((b == 7) ? 32'd1 : 32'd0), "R2 byte read start", 64'(d), (b == 7) ? 64'd1 : 64'd0);
      end
      rd(3, 15, 2'd1, d, e);
      chk(d == 32'd3, "R3 half read ignores bit0", 64'(d), 64'd3);

      // R4: boot slot and empty slot discard writes
      wr(0, 4, 2'd2, 32'h0000_0000, w);
      chk(w == '0, "R4 boot slot no wake", 64'(w), 64'd0);
      rd(0, 4, 2'd2, d, e);
      chk(d == 32'd1, "R4 boot slot unchanged", 64'(d), 64'd1);
      wr(5, 4, 2'd2, 32'h0000_0000, w);
      chk(w == '0, "R4 empty slot no wake", 64'(w), 64'd0);
      rd(5, 4, 2'd2, d, e);
      chk(d == 32'd1, "R4 empty slot unchanged", 64'(d), 64'd1);

      // R10: illegal sizes
      wr(1, 4, 2'd3, 32'h0000_0000, w);
      chk(w == '0, "R10 bad write no wake", 64'(w), 64'd0);
      rd(1, 4, 2'd2, d, e);
      chk(d == 32'd1, "R10 bad write ignored", 64'(d), 64'd1);
      rd(1, 4, 2'd3, d, e);
      chk(e == 1'b1 && d == 32'd0, "R10 bad read err", {31'd0, e, d}, {31'd0, 1'b1, 32'd0});
      rd(1, 4, 2'd2, d, e);
      chk(e == 1'b0, "R10 err clears", 64'(e), 64'd0);

      // R3 R5 R6 R7 R8: release each secondary core
      for (int c = 1; c < CORES; c++) begin
         logic [31:0] lw;
         logic [63:0] st, ag;
         lw = 32'h0A12_3455 + (32'(c) << 24);
         ag = {32'hA000_0000 | 32'(c), 16'hBEEF, 16'(c)};
         wr(c, 8, 2'd2, ag[63:32], w);
         wr(c, 13, 2'd1, 32'(ag[31:16]), w);
         wr(c, 14, 2'd1, 32'(ag[15:0]), w);
         rd(c, 12, 2'd2, d, e);
         chk(d == ag[31:0], "R3 halfword writes", 64'(d), 64'(ag[31:0]));
         wr(c, 0, 2'd2, 32'(c), w);
         chk(w == '0, "R5 hold high word", 64'(w), 64'd0);
         wr(c, 4, 2'd2, lw, w);
         chk(w == '0, "R5 hold bit set", 64'(w), 64'd0);
         wr(c, 7, 2'd0, 32'(lw[7:0] & 8'hFE), w);
         st = {32'(c), lw[31:8], lw[7:0] & 8'hFE};
         chk(w == CORES'(1 << c), "R5 wake strobe", 64'(w), 64'(1 << c));
         chk(wake_ofs == (st & MSK), "R6 offset", wake_ofs, st & MSK);
         chk(wake_base == (st & ~MSK), "R6 base", wake_base, st & ~MSK);
         chk(wake_size == 64'h0400_0000, "R6 size", wake_size, 64'h0400_0000);
         chk(wake_arg == ag, "R7 argument", wake_arg, ag);
         @(negedge clk);
         chk(wake == '0, "R5 single cycle", 64'(wake), 64'd0);
         rd(c, 20, 2'd2, d, e);
         chk(d == 32'hC0DE_0000 + 32'(c * 17), "R8 id stamped", 64'(d), 64'(32'hC0DE_0000 + 32'(c * 17)));
      end

      // R9: no second strobe, re-arm through hold
      wr(1, 6, 2'd0, 32'h0000_0077, w);
      chk(w == '0, "R9 no repeat", 64'(w), 64'd0);
      wr(1, 7, 2'd0, 32'h0000_0011, w);
      chk(w == '0, "R9 back to hold", 64'(w), 64'd0);
      wr(1, 7, 2'd0, 32'h0000_0010, w);
      chk(w == 4'b0010, "R9 rearmed", 64'(w), 64'd2);
      chk(wake_ofs == ((64'h0000_0001_0B12_7710) & MSK), "R9 R6 offset",
          wake_ofs, 64'h0000_0001_0B12_7710 & MSK);

      // R11: reads have no side effects
      for (int o = 0; o < 32; o += 4) begin
         logic [31:0] a, b2;
         rd(2, o, 2'd2, a, e);
         chk(wake == '0, "R11 read no wake", 64'(wake), 64'd0);
         rd(2, o, 2'd2, b2, e);
         chk(a == b2, "R11 read stable", 64'(b2), 64'(a));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule